// File: doc/BRIEF.md
# Warp Issue Scheduler

This block picks which resident warp issues next into an execution datapath that is narrower than a warp. Every cycle in which the datapath is free, it looks at all resident warps. A warp can be chosen only if it is resident and its next instruction has every operand available; the readiness comes in from outside. Among those warps it takes the one with the highest 4-bit priority. When several warps share that priority, a rotating pointer breaks the tie, so that every warp at that priority gets its turn.

A chosen warp holds the datapath for one beat per lane group. With 32 threads and 8 lanes, that is four beats, with lane groups 0 to 3 sent in order. The next choice is made during the last beat of the current warp, so a new warp starts on the very next cycle and no cycle is lost between warps. When nothing is eligible, the block outputs an idle slot. Its outputs are registered, and a choice appears one clock edge after the inputs it was based on.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is high, and on the first cycle after it, issue_valid and busy are 0 and issue_lane_grp is 0. The tie pointer starts at warp 0.
- R2: A warp is issued only if its bit in warp_valid and its bit in warp_ready were both 1 at the clock edge that made the selection.
- R3: The issued warp has the largest value in its 4-bit field of warp_prio among the eligible warps. Warp i uses bits [4*i+3:4*i].
- R4: Ties at the top priority go to the first eligible warp found by scanning upward from the pointer, wrapping from warp 23 to warp 0. After each issue the pointer moves to the issued warp plus one, modulo 24.
- R5: An issued warp is shown for four consecutive cycles. issue_lane_grp is 0, 1, 2, 3 on those cycles and issue_warp stays the same.
- R6: If a warp is eligible at the edge that ends lane group 3, the next cycle shows a new issue with lane group 0. There is no idle cycle between the two warps.
- R7: If no warp is eligible at a free slot, the next cycle shows issue_valid 0, issue_lane_grp 0 and busy 0.
- R8: Changes to warp_valid, warp_ready or warp_prio during lane groups 0 to 2 do not change the warp being dispatched or its lane sequence.
- R9: busy is 1 during lane groups 0 to 2 of a dispatch. It is 0 during lane group 3 and 0 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| warp_valid | input | 24 | Warp slot holds a resident warp |
| warp_ready | input | 24 | All operands of the warp's next instruction are available |
| warp_prio | input | 96 | 4-bit priority for each warp, warp i in bits [4i+3:4i] |
| issue_valid | output | 1 | A warp is being dispatched this cycle |
| issue_warp | output | 5 | Id of the warp being dispatched |
| issue_lane_grp | output | 2 | Lane group being sent this cycle |
| busy | output | 1 | Datapath is held; no selection at the coming edge |

## Verification
The hardest case to reach from the ports is a tie at the top priority, resolved against a pointer that has already wrapped past warp 23. To hit it, the bench draws priorities from a set of only three values, so ties are frequent. It also runs long stretches in which many warps are ready, so the pointer keeps moving around the ring. A separate directed phase changes readiness and priority in the middle of a dispatch. This checks that only the edge ending lane group 3 samples the inputs.

// File: rtl/wis_pkg.sv
package wis_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_SEND = 1'b1
  } phase_e;
endpackage

// File: rtl/wis_prio_max.sv
module wis_prio_max #(
  parameter int N  = 24,
  parameter int PW = 4
) (
  input  logic [N-1:0]    elig,
  input  logic [N*PW-1:0] prio,
  output logic [N-1:0]    top_mask,
  output logic            any_elig
);
  logic [PW-1:0] pr [N];
  logic [PW-1:0] best;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_unpack
      assign pr[g] = prio[g*PW +: PW];
    end
  endgenerate

  always_comb begin
    best = '0;
    any_elig = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!any_elig || pr[i] > best)) begin
        best = pr[i];
        any_elig = 1'b1;
      end
    end
  end

  generate
    for (g = 0; g < N; g++) begin : g_mask
      assign top_mask[g] = elig[g] && (pr[g] == best);
    end
  endgenerate
endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
  parameter int N   = 24,
  parameter int IDW = 5
) (
  input  logic [N-1:0]   req,
  input  logic [IDW-1:0] ptr,
  output logic [IDW-1:0] pick,
  output logic           found
);
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = idx[IDW-1:0];
      end
    end
  end
endmodule

// File: rtl/wis_dispatch.sv
module wis_dispatch
  import wis_pkg::*;
#(
  parameter int N     = 24,
  parameter int IDW   = 5,
  parameter int BEATS = 4,
  parameter int BW    = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           found,
  input  logic [IDW-1:0] pick,
  output logic           issue_valid,
  output logic [IDW-1:0] issue_warp,
  output logic [BW-1:0]  issue_lane_grp,
  output logic           busy,
  output logic [IDW-1:0] ptr
);
  localparam logic [BW-1:0]  LAST = BW'(BEATS - 1);
  localparam logic [IDW-1:0] TOP  = IDW'(N - 1);

  phase_e        phase_q;
  logic [BW-1:0] grp_q;
  logic          slot_free;

  assign issue_valid    = (phase_q == PH_SEND);
  assign issue_lane_grp = grp_q;
  assign slot_free      = (phase_q == PH_IDLE) || (grp_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      grp_q      <= '0;
      issue_warp <= '0;
      busy       <= 1'b0;
      ptr        <= '0;
    end else if (slot_free) begin
      grp_q <= '0;
      if (found) begin
        phase_q    <= PH_SEND;
        issue_warp <= pick;
        busy       <= (LAST != '0);
        ptr        <= (pick == TOP) ? '0 : pick + 1'b1;
      end else begin
        phase_q <= PH_IDLE;
        busy    <= 1'b0;
      end
    end else begin
      grp_q <= grp_q + 1'b1;
      busy  <= (grp_q + 1'b1) != LAST;
    end
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS    = 24,
  parameter int PRIO_W       = 4,
  parameter int WARP_THREADS = 32,
  parameter int LANES        = 8,
  localparam int ID_W        = $clog2(NUM_WARPS),
  localparam int BEATS       = WARP_THREADS / LANES,
  localparam int BEAT_W      = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_WARPS-1:0]        warp_valid,
  input  logic [NUM_WARPS-1:0]        warp_ready,
  input  logic [NUM_WARPS*PRIO_W-1:0] warp_prio,
  output logic                        issue_valid,
  output logic [ID_W-1:0]             issue_warp,
  output logic [BEAT_W-1:0]           issue_lane_grp,
  output logic                        busy
);
  logic [NUM_WARPS-1:0] elig;
  logic [NUM_WARPS-1:0] top_mask;
  logic                 any_elig;
  logic [ID_W-1:0]      ptr;
  logic [ID_W-1:0]      pick;
  logic                 found;

  assign elig = warp_valid & warp_ready;

  wis_prio_max #(.N(NUM_WARPS), .PW(PRIO_W)) u_max (
    .elig     (elig),
    .prio     (warp_prio),
    .top_mask (top_mask),
    .any_elig (any_elig)
  );

  wis_rr_pick #(.N(NUM_WARPS), .IDW(ID_W)) u_pick (
    .req   (top_mask),
    .ptr   (ptr),
    .pick  (pick),
    .found (found)
  );

  wis_dispatch #(.N(NUM_WARPS), .IDW(ID_W), .BEATS(BEATS), .BW(BEAT_W)) u_disp (
    .clk            (clk),
    .rst            (rst),
    .found          (found && any_elig),
    .pick           (pick),
    .issue_valid    (issue_valid),
    .issue_warp     (issue_warp),
    .issue_lane_grp (issue_lane_grp),
    .busy           (busy),
    .ptr            (ptr)
  );
endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
  parameter int N     = 24,
  parameter int IDW   = 5,
  parameter int BW    = 2,
  parameter int BEATS = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   warp_valid,
  input logic [N-1:0]   warp_ready,
  input logic           issue_valid,
  input logic [IDW-1:0] issue_warp,
  input logic [BW-1:0]  issue_lane_grp,
  input logic           busy
);
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);
  logic [N-1:0] elig_q;
  logic         rst_q;

  always_ff @(posedge clk) begin
    elig_q <= warp_valid & warp_ready;
    rst_q  <= rst;
  end

  always @(posedge clk) begin
    if (rst_q) begin
      a_reset_r1: assert (!issue_valid && !busy && issue_lane_grp == '0);
    end
  end

  p_elig_r2: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_lane_grp == '0) |-> elig_q[issue_warp]);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_lane_grp != LAST) |=>
      (issue_valid && issue_lane_grp == $past(issue_lane_grp) + 1'b1 && $stable(issue_warp)));

  p_zero_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_lane_grp == LAST && |(warp_valid & warp_ready)) |=>
      (issue_valid && issue_lane_grp == '0));

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    ((!issue_valid || issue_lane_grp == LAST) && !(|(warp_valid & warp_ready))) |=>
      (!issue_valid && !busy && issue_lane_grp == '0));

  p_busy_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> (issue_valid && issue_lane_grp != LAST));
endmodule

bind warp_issue_sched wis_checker #(
  .N(NUM_WARPS), .IDW(ID_W), .BW(BEAT_W), .BEATS(BEATS)
) u_chk (
  .clk(clk), .rst(rst), .warp_valid(warp_valid), .warp_ready(warp_ready),
  .issue_valid(issue_valid), .issue_warp(issue_warp),
  .issue_lane_grp(issue_lane_grp), .busy(busy)
);

// File: tb/warp_issue_sched_tb.sv
module warp_issue_sched_tb;
  localparam int N = 24;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  warp_valid = '0;
  logic [N-1:0]  warp_ready = '0;
  logic [N*PW-1:0] warp_prio = '0;
  logic          issue_valid;
  logic [4:0]    issue_warp;
  logic [1:0]    issue_lane_grp;
  logic          busy;

  int tests = 0;
  int fails = 0;

  // expected state
  bit m_valid;
  int m_warp, m_grp, m_ptr;

  always #10 clk = ~clk;

  warp_issue_sched u_dut (
    .clk(clk), .rst(rst), .warp_valid(warp_valid), .warp_ready(warp_ready),
    .warp_prio(warp_prio), .issue_valid(issue_valid), .issue_warp(issue_warp),
    .issue_lane_grp(issue_lane_grp), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: model the next state from requirements, then compare
  task automatic tick();
    if (rst) begin
      m_valid = 0; m_grp = 0; m_ptr = 0;
    end else if (!m_valid || m_grp == 3) begin
      int best = -1;
      int w = -1;
      for (int i = 0; i < N; i++)
        if (warp_valid[i] && warp_ready[i] && int'(warp_prio[i*PW +: PW]) > best)
          best = int'(warp_prio[i*PW +: PW]);
      for (int k = 0; k < N; k++) begin
        int idx = (m_ptr + k) % N;
        if (w < 0 && best >= 0 && warp_valid[idx] && warp_ready[idx] &&
            int'(warp_prio[idx*PW +: PW]) == best) w = idx;
      end
      m_grp = 0;
      if (w >= 0) begin
        m_valid = 1; m_warp = w; m_ptr = (w + 1) % N;
      end else m_valid = 0;
    end else m_grp++;
    @(posedge clk);
    #2;
    if (rst) begin
      chk(!issue_valid && !busy && issue_lane_grp == 0, "R1 reset outputs",
          {issue_valid, busy, issue_lane_grp}, 0);
    end else begin
      chk(issue_valid == m_valid, "R2/R7 issue_valid", issue_valid, m_valid);
      chk(int'(issue_lane_grp) == m_grp, "R5/R7 lane group", issue_lane_grp, m_grp);
      chk(busy == (m_valid && m_grp != 3), "R9 busy", busy, m_valid && m_grp != 3);
      if (m_valid)
        chk(int'(issue_warp) == m_warp, "R3/R4 warp id", issue_warp, m_warp);
    end
  endtask

  task automatic set_prio(input int w, input int p);
    warp_prio[w*PW +: PW] = PW'(p);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int issues;
    int w0;
    @(negedge clk);
    repeat (3) tick();                    // R1
    rst = 1'b0;
    tick();
    chk(!issue_valid && !busy, "R1 first cycle after reset", issue_valid, 0);

    // R7: resident but nothing ready; R2: ready but not resident
    warp_valid = '1; warp_ready = '0;
    repeat (4) tick();
    warp_valid = '0; warp_ready = '1;
    repeat (4) tick();
    chk(!issue_valid, "R2 ready without valid not issued", issue_valid, 0);

    // R5: single warp
    warp_valid = '0; warp_ready = '0; warp_valid[5] = 1; warp_ready[5] = 1;
    repeat (9) tick();

    // R3: priority
    warp_valid = '1; warp_ready = '1; warp_prio = '0;
    set_prio(3, 2); set_prio(17, 11);
    tick(); repeat (3) tick();
    chk(m_warp == 17, "R3 highest priority chosen", m_warp, 17);

    // R4: four-way tie walks the ring, wrapping
    warp_prio = '0;
    set_prio(2, 7); set_prio(9, 7); set_prio(22, 7); set_prio(23, 7);
    repeat (40) tick();

    // R6: count issues over back-to-back dispatch
    issues = 0;
    for (int c = 0; c < 40; c++) begin
      tick();
      if (issue_valid && issue_lane_grp == 0) issues++;
    end
    chk(issues == 10, "R6 back-to-back issues in 40 cycles", issues, 10);

    // R8: inputs change mid-dispatch
    warp_prio = '0; warp_valid = '0; warp_ready = '0;
    warp_valid[4] = 1; warp_ready[4] = 1;
    repeat (2) tick();
    while (!(issue_valid && issue_lane_grp == 0)) tick();
    w0 = issue_warp;
    warp_ready = '0; warp_valid = '1; warp_ready[12] = 1; set_prio(12, 15);
    tick();
    chk(int'(issue_warp) == w0 && issue_lane_grp == 1, "R8 dispatch unchanged", issue_warp, w0);
    warp_ready = '1;
    tick();
    chk(int'(issue_warp) == w0 && issue_lane_grp == 2, "R8 dispatch unchanged", issue_warp, w0);
    repeat (6) tick();

    // random sweep with few priority levels to force ties
    for (int c = 0; c < 6000; c++) begin
      warp_valid = N'($urandom);
      warp_ready = (c % 50 < 10) ? '0 : N'($urandom);
      for (int i = 0; i < N; i++) set_prio(i, int'($urandom % 3));
      if (c == 3000) begin
        rst = 1'b1; tick(); rst = 1'b0;
      end
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule